// File: doc/BRIEF.md
# Multi-Size Sequential Unsigned Divider

This block divides an unsigned dividend of twice the divisor width by an unsigned divisor. It returns a quotient and a remainder, each as wide as the divisor. A two-bit size code selects one of three operand sizes: 8-bit divisor, 16-bit divisor or 32-bit divisor. The datapath always has the full width, and narrower sizes use only the low bits of each input port.

A one-cycle `start_i` pulse latches the operands. `busy_o` then stays high until the operation ends. `done_o` pulses for one cycle when the outcome is ready. Before any iteration begins, the block tests whether the quotient can fit. If the upper half of the dividend is not smaller than the divisor, the block takes an early exit and raises `div_err_o`. This test also covers a zero divisor. On the early exit the quotient and remainder outputs keep their earlier values. Otherwise a restoring divider produces one quotient bit per clock. The fixed overhead makes the latency an exact function of the size code.

The flag output carries architecturally undefined status. It is driven to zero so that behaviour is deterministic.

Top module: `mdiv_core`

## Requirements
- R1: The size code `size_i` selects the operand widths. Code 0 uses dividend bits [15:0] and divisor bits [7:0]. Code 1 uses dividend bits [31:0] and divisor bits [15:0]. Codes 2 and 3 both use dividend bits [63:0] and divisor bits [31:0]. Bits above the selected width have no effect on any output, and the unused upper bits of `quotient_o` and `remainder_o` read zero.
- R2: On success, `quotient_o` equals the selected dividend divided by the selected divisor, rounded down. `remainder_o` equals the dividend modulo the divisor, and it is strictly less than the divisor.
- R3: When the upper half of the selected dividend is greater than or equal to the selected divisor, the operation ends with `div_err_o` = 1. In that case `quotient_o` and `remainder_o` keep their previous values.
- R4: A selected divisor of zero ends with `div_err_o` = 1. This holds even when divisor bits above the selected width are nonzero.
- R5: On success, `done_o` is a one-cycle pulse. It is high after the 14th (code 0), 22nd (code 1) or 38th (codes 2 and 3) rising edge that follows the edge where `start_i` was sampled. `busy_o` is high from that start edge until `done_o` rises.
- R6: On a divide error, `done_o` pulses after the 2nd rising edge that follows the start edge.
- R7: The block ignores `start_i` while `busy_o` is high. The operation in progress completes with its original operands and latency.
- R8: The outputs `quotient_o`, `remainder_o` and `div_err_o` stay stable from `done_o` until the next accepted start. An accepted start clears `div_err_o`.
- R9: `flags_o` reads zero at all times.
- R10: After synchronous reset, `busy_o`, `done_o` and `div_err_o` are 0, and `quotient_o` and `remainder_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| size_i | input | 2 | Operand size code (0: 16/8, 1: 32/16, 2 or 3: 64/32) |
| dividend_i | input | 64 | Dividend, right-aligned |
| divisor_i | input | 32 | Divisor, right-aligned |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Last operation trapped (overflow or zero divisor) |
| quotient_o | output | 32 | Quotient of the last successful operation |
| remainder_o | output | 32 | Remainder of the last successful operation |
| flags_o | output | 6 | Undefined status, driven to zero |

## Verification
The hardest situations to reach from the ports are a start pulse that arrives mid-operation, and a divisor whose selected bits are zero while its unused upper bits are not. To reach the first, the stimulus raises start with different operands while an operation is running, then checks that the result and the latency belong to the first request. For the second, the vector table contains entries with junk above the selected widths. One of these hides a zero byte divisor under nonzero upper bits, which must still trap on the two-cycle path without disturbing the held quotient and remainder.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;

    // Operand size selection codes
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_ALIAS = 2'd3
    } size_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CHECK = 2'd1,
        PH_ITER  = 2'd2,
        PH_TAIL  = 2'd3
    } phase_e;

    // Strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;    // accept operands
        logic seed;    // initialise partial remainder and quotient shifter
        logic step;    // one restoring iteration
        logic finish;  // commit results
        logic trap;    // current operation ends in divide error
    } ctl_s;

    // Map a size code onto the lane index used by the front end
    function automatic logic [1:0] lane_of(input logic [1:0] sz);
        return (sz == SZ_ALIAS) ? 2'(SZ_DWORD) : sz;
    endfunction

endpackage

// File: rtl/mdiv_front.sv
module mdiv_front
    import mdiv_pkg::*;
#(
    parameter int DW = 32,
    localparam int CW = $clog2(DW + 1) + 1
) (
    input  logic [1:0]      size,
    input  logic [2*DW-1:0] dividend,
    input  logic [DW-1:0]   divisor,
    output logic [DW-1:0]   hi_half,
    output logic [DW-1:0]   lo_aligned,
    output logic [DW-1:0]   dvs_sel,
    output logic [CW-1:0]   nbits,
    output logic            ovf
);

    localparam int LANES = 3;

    logic [DW-1:0] hi_c  [LANES];
    logic [DW-1:0] lo_c  [LANES];
    logic [DW-1:0] dv_c  [LANES];
    logic [CW-1:0] nb_c  [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int            B    = DW >> (LANES - 1 - g);
        localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - B);
        logic [2*DW-1:0] shifted;
        assign shifted  = dividend >> B;
        assign hi_c[g]  = shifted[DW-1:0] & MASK;
        assign lo_c[g]  = (dividend[DW-1:0] & MASK) << (DW - B);
        assign dv_c[g]  = divisor & MASK;
        assign nb_c[g]  = CW'(B);
    end

    logic [1:0] lane;
    assign lane       = lane_of(size);
    assign hi_half    = hi_c[lane];
    assign lo_aligned = lo_c[lane];
    assign dvs_sel    = dv_c[lane];
    assign nbits      = nb_c[lane];

    // Quotient cannot fit when the upper half already reaches the divisor;
    // a zero divisor always satisfies this.
    assign ovf = (hi_half >= dvs_sel);

endmodule

// File: rtl/mdiv_step.sv
module mdiv_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] rem,
    input  logic [DW-1:0] qsh,
    input  logic [DW-1:0] dvs,
    output logic [DW-1:0] rem_nx,
    output logic [DW-1:0] qsh_nx
);

    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    always_comb begin
        trial  = {rem, qsh[DW-1]};
        fits   = (trial >= {1'b0, dvs});
        diff   = trial - {1'b0, dvs};
        rem_nx = fits ? diff[DW-1:0] : trial[DW-1:0];
        qsh_nx = {qsh[DW-2:0], fits};
    end

endmodule

// File: rtl/mdiv_ctrl.sv
module mdiv_ctrl
    import mdiv_pkg::*;
#(
    parameter int DW  = 32,
    parameter int OVH = 6,
    localparam int CW = $clog2(DW + OVH + 1) + 1,
    localparam int NW = $clog2(DW + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] nbits,
    input  logic          ovf,
    output logic          busy,
    output logic          done,
    output ctl_s          ctl
);

    localparam logic [CW-1:0] TAIL_N = CW'(OVH - 2);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          trap_q;

    always_comb begin
        ctl.load   = (phase == PH_IDLE) && start;
        ctl.seed   = (phase == PH_CHECK) && !ovf;
        ctl.step   = (phase == PH_ITER);
        ctl.finish = (phase == PH_TAIL) && (cnt == '0);
        ctl.trap   = trap_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_CHECK;
                        busy  <= 1'b1;
                    end
                end
                PH_CHECK: begin
                    if (ovf) begin
                        phase  <= PH_TAIL;
                        cnt    <= '0;
                        trap_q <= 1'b1;
                    end else begin
                        phase  <= PH_ITER;
                        cnt    <= CW'(nbits) - 1'b1;
                        trap_q <= 1'b0;
                    end
                end
                PH_ITER: begin
                    if (cnt == '0) begin
                        phase <= PH_TAIL;
                        cnt   <= TAIL_N;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        busy  <= 1'b0;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                   // R5
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                             // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ctl.finish) |=> busy);          // R7
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ITER) |-> (cnt < CW'(nbits)));        // R5

endmodule

// File: rtl/mdiv_core.sv
module mdiv_core
    import mdiv_pkg::*;
#(
    parameter int DW  = 32,
    parameter int OVH = 6,
    parameter int FW  = 6,
    localparam int NW = $clog2(DW + 1) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [1:0]      size_i,
    input  logic [2*DW-1:0] dividend_i,
    input  logic [DW-1:0]   divisor_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            div_err_o,
    output logic [DW-1:0]   quotient_o,
    output logic [DW-1:0]   remainder_o,
    output logic [FW-1:0]   flags_o
);

    ctl_s ctl;

    logic [1:0]      size_q;
    logic [2*DW-1:0] dvd_q;
    logic [DW-1:0]   dvs_q;

    logic [DW-1:0]   hi_half, lo_aligned, dvs_sel;
    logic [NW-1:0]   nbits;
    logic            ovf;

    logic [DW-1:0]   rem_q, qsh_q;
    logic [DW-1:0]   rem_nx, qsh_nx;

    mdiv_front #(.DW(DW)) u_front (
        .size       (size_q),
        .dividend   (dvd_q),
        .divisor    (dvs_q),
        .hi_half    (hi_half),
        .lo_aligned (lo_aligned),
        .dvs_sel    (dvs_sel),
        .nbits      (nbits),
        .ovf        (ovf)
    );

    mdiv_ctrl #(.DW(DW), .OVH(OVH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .nbits (nbits),
        .ovf   (ovf),
        .busy  (busy_o),
        .done  (done_o),
        .ctl   (ctl)
    );

    mdiv_step #(.DW(DW)) u_step (
        .rem    (rem_q),
        .qsh    (qsh_q),
        .dvs    (dvs_sel),
        .rem_nx (rem_nx),
        .qsh_nx (qsh_nx)
    );

    // Operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
        end else if (ctl.load) begin
            size_q <= size_i;
            dvd_q  <= dividend_i;
            dvs_q  <= divisor_i;
        end
    end

    // Iteration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            qsh_q <= '0;
        end else if (ctl.seed) begin
            rem_q <= hi_half;
            qsh_q <= lo_aligned;
        end else if (ctl.step) begin
            rem_q <= rem_nx;
            qsh_q <= qsh_nx;
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            quotient_o  <= '0;
            remainder_o <= '0;
            div_err_o   <= 1'b0;
            flags_o     <= '0;
        end else begin
            flags_o <= '0;
            if (ctl.load) begin
                div_err_o <= 1'b0;
            end else if (ctl.finish) begin
                div_err_o <= ctl.trap;
                if (!ctl.trap) begin
                    quotient_o  <= qsh_q;
                    remainder_o <= rem_q;
                end
            end
        end
    end

    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (rem_q < dvs_sel));                       // R2
    AST_REMAINDER_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (done_o && !div_err_o) |-> (remainder_o < dvs_sel));  // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done_o && div_err_o) |-> ($stable(quotient_o) && $stable(remainder_o))); // R3
    AST_ZERO_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (done_o && (dvs_sel == '0)) |-> div_err_o);            // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> ($stable(quotient_o) && $stable(remainder_o))); // R8

endmodule

// File: tb/mdiv_core_bench.sv
module mdiv_core_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [1:0]  size_i;
    logic [63:0] dividend_i;
    logic [31:0] divisor_i;
    logic        busy_o, done_o, div_err_o;
    logic [31:0] quotient_o, remainder_o;
    logic [5:0]  flags_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mdiv_core u_mdiv_core (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .size_i      (size_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .div_err_o   (div_err_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .flags_o     (flags_o)
    );

    // {size, dividend, divisor}
    localparam int NV = 13;
    localparam logic [97:0] VEC [NV] = '{
        {2'd0, 64'h0000_0000_0000_0064, 32'h0000_0007},
        {2'd0, 64'h0000_0000_0000_00FF, 32'h0000_00FF},
        {2'd0, 64'h0000_0000_0000_FE01, 32'h0000_00FF},
        {2'd1, 64'h0000_0000_1234_5678, 32'h0000_9ABC},
        {2'd1, 64'h0000_0000_FFFF_0000, 32'h0000_FFFF},
        {2'd2, 64'h0000_0001_0000_0000, 32'h0000_0002},
        {2'd2, 64'h0123_4567_89AB_CDEF, 32'hFEDC_BA98},
        {2'd3, 64'h0000_0000_FFFF_FFFF, 32'h0000_0001},
        {2'd0, 64'hDEAD_BEEF_CAFE_0A11, 32'h1234_5680},
        {2'd1, 64'h0000_0000_0010_0000, 32'h0000_0000},
        {2'd2, 64'h0000_0000_0000_0005, 32'h0000_0000},
        {2'd0, 64'h0000_0000_0000_0500, 32'h0000_0005},
        {2'd0, 64'h7777_0000_0000_0123, 32'hFFFF_FF00}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Run one operation; optionally poke start with other operands while busy.
    task automatic run_op(input logic [1:0] sz, input logic [63:0] dvd,
                          input logic [31:0] dvs, input bit poke);
        int          b;
        int          lat_exp;
        int          n;
        logic [63:0] mask, dm, dv, hi, q_exp, r_exp;
        logic [31:0] q_prev, r_prev;
        bit          err_exp;
        b       = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask    = (64'd1 << b) - 64'd1;
        dm      = (b == 32) ? dvd : (dvd & ((64'd1 << (2 * b)) - 64'd1));
        dv      = {32'd0, dvs} & mask;
        hi      = dm >> b;
        err_exp = (hi >= dv);
        q_exp   = err_exp ? 64'd0 : dm / dv;
        r_exp   = err_exp ? 64'd0 : dm % dv;
        lat_exp = err_exp ? 2 : b + 6;
        q_prev  = quotient_o;
        r_prev  = remainder_o;

        @(negedge clk);
        size_i     = sz;
        dividend_i = dvd;
        divisor_i  = dvs;
        start_i    = 1'b1;
        @(negedge clk);
        start_i    = 1'b0;
        n = 0;
        while (n < 100) begin
            if (poke && n == 1) begin
                start_i    = 1'b1;
                size_i     = 2'd0;
                dividend_i = 64'h0000_0000_0000_0042;
                divisor_i  = 32'h0000_00F1;
            end else begin
                start_i    = 1'b0;
            end
            @(negedge clk);
            n++;
            if (n == 1 && !done_o)
                check(busy_o == 1'b1, "R5", "busy during op", 64'(busy_o), 64'd1);
            if (done_o) break;
        end
        start_i = 1'b0;
        if (poke)
            check(n == lat_exp, "R7", "latency with ignored start", 64'(n), 64'(lat_exp));
        else if (err_exp)
            check(n == lat_exp, "R6", "error latency", 64'(n), 64'(lat_exp));
        else
            check(n == lat_exp, "R5", "latency", 64'(n), 64'(lat_exp));
        check(div_err_o == err_exp, (dv == 0) ? "R4" : "R3", "div_err",
              64'(div_err_o), 64'(err_exp));
        if (err_exp) begin
            check(quotient_o == q_prev && remainder_o == r_prev, "R3",
                  "results unchanged on trap", {quotient_o, remainder_o}, {q_prev, r_prev});
        end else begin
            check(64'(quotient_o) == q_exp, poke ? "R7" : "R2", "quotient",
                  64'(quotient_o), q_exp);
            check(64'(remainder_o) == r_exp, poke ? "R7" : "R1", "remainder",
                  64'(remainder_o), r_exp);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R5", "done is one cycle", 64'(done_o), 64'd0);
        check(flags_o == 6'd0, "R9", "flags zero", 64'(flags_o), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] hq, hr;
        logic        he;
        rst        = 1'b1;
        start_i    = 1'b0;
        size_i     = 2'd0;
        dividend_i = '0;
        divisor_i  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(busy_o == 0 && done_o == 0 && div_err_o == 0, "R10", "control after reset",
              {61'd0, busy_o, done_o, div_err_o}, 64'd0);
        check(quotient_o == 0 && remainder_o == 0, "R10", "results after reset",
              {quotient_o, remainder_o}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][97:96], VEC[i][95:32], VEC[i][31:0], 1'b0);
        end

        // R7: start pulse while busy is ignored
        run_op(2'd1, 64'h0000_0000_0BAD_F00D, 32'h0000_1234, 1'b1);
        run_op(2'd2, 64'h0000_0000_DEAD_BEEF, 32'h0000_0013, 1'b1);

        // R8: outputs held after completion while inputs change
        run_op(2'd1, 64'h0000_0000_0001_0000, 32'h0000_0000, 1'b0);
        hq = quotient_o; hr = remainder_o; he = div_err_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            size_i     = 2'(k);
            dividend_i = {32'(k) * 32'h1111_1111, 32'hFFFF_FFFF};
            divisor_i  = 32'(k);
        end
        check(quotient_o == hq && remainder_o == hr && div_err_o == he, "R8",
              "hold until next start", {quotient_o, remainder_o},
              {hq, hr});
        // R8: accepted start clears div_err
        @(negedge clk);
        size_i = 2'd0; dividend_i = 64'd50; divisor_i = 32'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(div_err_o == 1'b0, "R8", "error cleared by start", 64'(div_err_o), 64'd0);
        repeat (20) @(negedge clk);
        check(quotient_o == 32'd5 && remainder_o == 32'd5, "R2", "small byte divide",
              {quotient_o, remainder_o}, {32'd5, 32'd5});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule